// File: doc/BRIEF.md
# Nibble-Serial Cartridge Mapper Controller

This block is the memory controller of a cartridge. The host reaches it through a two-address control window. Writing the odd address loads a register-index latch. Writing the even address stores a 4-bit nibble into the register that the latch selects. A small nibble register file holds the ROM bank number, a staged data byte, a control/select nibble and a RAM address nibble. Together these drive a ROM bank output and a 32-byte save RAM held inside the block.

A byte reaches save RAM in several steps. The host sets the control nibble and the two data nibbles, then writes the RAM address-low register, and that write fires the operation the control nibble selects. Read-back uses the same window. The host points the index latch at a status or result index and reads the even address. Reads are combinational from the current register and RAM state. Register writes and RAM writes take effect on the clock edge that samples the write strobe.

Top module: `nib_mapper`

## Requirements
- R1: After reset the index latch and every nibble register are zero, so the ROM bank output is zero and an even read with index 0 returns 0xF1.
- R2: A write only counts when the three page bits equal 5. Writes on any other page change neither the index latch nor any register.
- R3: A write to the odd address (port select 1) loads all 8 data bits into the index latch.
- R4: A write to the even address stores data bits 3:0 into the register picked by the index. The indices are 0 bank low, 1 bank high, 4 data low, 5 data high, 6 control and 7 RAM address low. An index of 8 or more stores nothing, including values such as 0x10 whose low bits name a real register.
- R5: The ROM bank output equals bank_low OR (bank_high shifted left by 4) and follows each write to index 0 or 1.
- R6: A write to index 7 while control bits 3:1 equal 0 stores the byte {data high, data low} at RAM address {control bit 0, new address-low nibble}.
- R7: A write to index 7 while control bits 3:1 are not 0 leaves save RAM unchanged.
- R8: A read of the odd address inside the window returns 0xFF.
- R9: An even read returns 0xF1 when the index is 0x0A, and also for any index other than 0x0C and 0x0D.
- R10: An even read with index 0x0C returns 0xF0 OR the low nibble of the RAM byte at {control bit 0, address low}, and index 0x0D returns 0xF0 OR its high nibble, but only while control bits 3:1 equal 1. Otherwise both return 0xF0.
- R11: Without the read strobe, or outside the window, the read data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_page | input | 3 | Host address bits 15:13 |
| host_a0 | input | 1 | Host address bit 0: 1 selects the index port, 0 the data port |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, sampled on the clock edge |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, combinational |
| rom_bank | output | 8 | ROM bank number |

## Verification
The bench stores a random byte at all 32 RAM locations and reads both nibbles of each one back. A design that ignored control bit 0 in the address would alias the two halves of the RAM. A design that swapped the data nibbles would return the high and low halves the wrong way round. The bench writes index 0x10 and index 8 and checks that no register changes; a latch that decoded only the low index bits would overwrite bank low or control. It also fires the trigger with a non-store command and with a read-setup command, then checks that RAM still holds its old byte. Bank writes over all 5-bit values check the shift of the high nibble, and off-window writes check that the page is decoded.

// File: rtl/nm_pkg.sv
package nm_pkg;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = 8;
  localparam int NREG   = 8;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int RAM_AW = NIB_W + 1;

  localparam logic [IDX_W-1:0] IX_BANK_LO = 8'h00;
  localparam logic [IDX_W-1:0] IX_BANK_HI = 8'h01;
  localparam logic [IDX_W-1:0] IX_WDAT_LO = 8'h04;
  localparam logic [IDX_W-1:0] IX_WDAT_HI = 8'h05;
  localparam logic [IDX_W-1:0] IX_CTRL    = 8'h06;
  localparam logic [IDX_W-1:0] IX_ADDR_LO = 8'h07;
  localparam logic [IDX_W-1:0] IX_READY   = 8'h0A;
  localparam logic [IDX_W-1:0] IX_RES_LO  = 8'h0C;
  localparam logic [IDX_W-1:0] IX_RES_HI  = 8'h0D;

  typedef enum logic [NIB_W-2:0] {
    OP_STORE = 3'd0,
    OP_FETCH = 3'd1
  } op_e;

  function automatic logic [NIB_W-2:0] op_of(input logic [NIB_W-1:0] ctrl);
    return ctrl[NIB_W-1:1];
  endfunction

  function automatic logic [RAM_AW-1:0] ram_addr(input logic [NIB_W-1:0] ctrl,
                                                 input logic [NIB_W-1:0] alo);
    return {ctrl[0], alo};
  endfunction

  function automatic logic [BYTE_W-1:0] join_nibs(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] even_read(input logic [IDX_W-1:0]  idx,
                                                  input logic [NIB_W-1:0]  ctrl,
                                                  input logic [BYTE_W-1:0] ram_b);
    logic [BYTE_W-1:0] v;
    v = 8'hF1;
    if (idx == IX_RES_LO || idx == IX_RES_HI) begin
      if (op_of(ctrl) == OP_FETCH)
        v = {4'hF, (idx == IX_RES_HI) ? ram_b[BYTE_W-1:NIB_W] : ram_b[NIB_W-1:0]};
      else
        v = 8'hF0;
    end
    return v;
  endfunction
endpackage

// File: rtl/nm_regfile.sv
module nm_regfile
  import nm_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int IW = IDX_W,
  parameter int NR = NREG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [IW-1:0] wdata,
  output logic [IW-1:0] index_q,
  output logic [NW-1:0] bank_lo,
  output logic [NW-1:0] bank_hi,
  output logic [NW-1:0] ctrl,
  output logic [NW-1:0] alo,
  output logic          store_evt,
  output logic          bank_evt,
  output logic [NW:0]   st_addr,
  output logic [2*NW-1:0] st_data
);
  logic [NW-1:0] nib_q [NR];
  logic          idx_in_range;

  always_ff @(posedge clk) begin
    if (!rst_n)      index_q <= '0;
    else if (idx_wr) index_q <= wdata;
  end

  assign idx_in_range = (index_q < IW'(NR));

  for (genvar i = 0; i < NR; i++) begin : g_nib
    always_ff @(posedge clk) begin
      if (!rst_n)
        nib_q[i] <= '0;
      else if (dat_wr && index_q == IW'(i))
        nib_q[i] <= wdata[NW-1:0];
    end
  end

  assign bank_lo = nib_q[IX_BANK_LO[2:0]];
  assign bank_hi = nib_q[IX_BANK_HI[2:0]];
  assign ctrl    = nib_q[IX_CTRL[2:0]];
  assign alo     = nib_q[IX_ADDR_LO[2:0]];

  assign bank_evt  = dat_wr && (index_q == IX_BANK_LO || index_q == IX_BANK_HI);
  assign store_evt = dat_wr && (index_q == IX_ADDR_LO) && (op_of(ctrl) == OP_STORE);
  assign st_addr   = ram_addr(ctrl, wdata[NW-1:0]);
  assign st_data   = join_nibs(nib_q[IX_WDAT_HI[2:0]], nib_q[IX_WDAT_LO[2:0]]);

  // R3: the index latch only moves on an index-port write
  a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(index_q));

  // R4: out-of-range indices leave the registers alone
  a_r4_high_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_in_range) |=> ($stable(ctrl) && $stable(alo) &&
                                   $stable(bank_lo) && $stable(bank_hi)));

  // R4: an in-range data write lands its nibble
  a_r4_nibble_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && index_q == IX_CTRL) |=> (ctrl == $past(wdata[NW-1:0])));
endmodule

// File: rtl/nm_sram.sv
module nm_sram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R6: a store puts its byte at its address
  a_r6_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/nm_readmux.sv
module nm_readmux
  import nm_pkg::*;
(
  input  logic              rd_en,
  input  logic              odd,
  input  logic [IDX_W-1:0]  index_q,
  input  logic [NIB_W-1:0]  ctrl,
  input  logic [BYTE_W-1:0] ram_b,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    if (!rd_en || odd) rdata = 8'hFF;
    else               rdata = even_read(index_q, ctrl, ram_b);
  end
endmodule

// File: rtl/nib_mapper.sv
module nib_mapper
  import nm_pkg::*;
#(
  parameter logic [2:0] WIN_PAGE = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_page,
  input  logic              host_a0,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [BYTE_W-1:0] host_rdata,
  output logic [BYTE_W-1:0] rom_bank
);
  logic              win_hit, idx_wr, dat_wr, rd_en;
  logic [IDX_W-1:0]  index_q;
  logic [NIB_W-1:0]  bank_lo, bank_hi, ctrl, alo;
  logic              store_evt, bank_evt;
  logic [RAM_AW-1:0] st_addr;
  logic [BYTE_W-1:0] st_data, ram_b;

  assign win_hit = (host_page == WIN_PAGE);
  assign idx_wr  = host_wr && win_hit && host_a0;
  assign dat_wr  = host_wr && win_hit && !host_a0;
  assign rd_en   = host_rd && win_hit;

  nm_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(host_wdata), .index_q(index_q), .bank_lo(bank_lo),
    .bank_hi(bank_hi), .ctrl(ctrl), .alo(alo), .store_evt(store_evt),
    .bank_evt(bank_evt), .st_addr(st_addr), .st_data(st_data)
  );

  nm_sram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(store_evt), .waddr(st_addr),
    .wdata(st_data), .raddr(ram_addr(ctrl, alo)), .rdata(ram_b)
  );

  nm_readmux u_rmux (
    .rd_en(rd_en), .odd(host_a0), .index_q(index_q), .ctrl(ctrl),
    .ram_b(ram_b), .rdata(host_rdata)
  );

  assign rom_bank = join_nibs(bank_hi, bank_lo);

  // R5: the bank moves only after a bank-register write
  a_r5_bank_on_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_bank) |-> $past(bank_evt));

  // R2: writes off the window change nothing
  a_r2_off_window: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !win_hit) |=> ($stable(index_q) && $stable(rom_bank) && $stable(ctrl)));

  // R8: odd-port reads
  a_r8_odd_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && host_a0) |-> (host_rdata == 8'hFF));

  // R11: idle read bus
  a_r11_idle_ff: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (host_rdata == 8'hFF));

  // R9 / R10: even reads always carry an all-ones high nibble
  a_r10_even_high_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !host_a0) |-> (host_rdata[7:4] == 4'hF));
endmodule

// File: tb/nib_mapper_bench.sv
module nib_mapper_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] host_page = 0;
  logic       host_a0 = 0;
  logic [7:0] host_wdata = 0;
  logic       host_wr = 0;
  logic       host_rd = 0;
  logic [7:0] host_rdata, rom_bank;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [32];

  always #4 clk = ~clk;

  nib_mapper u_nib_mapper (
    .clk(clk), .rst_n(rst_n), .host_page(host_page), .host_a0(host_a0),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .rom_bank(rom_bank)
  );

  function automatic logic [7:0] exp_bank(input logic [3:0] hi, input logic [3:0] lo);
    return (8'(hi) << 4) | 8'(lo);
  endfunction

  function automatic logic [7:0] exp_result(input bit hi_half, input logic [3:0] c,
                                            input logic [7:0] b);
    if ((c >> 1) != 4'd1) return 8'hF0;
    return 8'hF0 | (hi_half ? (b >> 4) : (b & 8'h0F));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] page, input bit a0, input logic [7:0] d);
    @(negedge clk);
    host_page = page; host_a0 = a0; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic setreg(input logic [7:0] idx, input logic [3:0] v);
    wr(3'd5, 1, idx);
    wr(3'd5, 0, {4'h0, v});
  endtask

  task automatic rd(input logic [2:0] page, input bit a0, input bit strobe,
                    output logic [7:0] v);
    @(negedge clk);
    host_page = page; host_a0 = a0; host_rd = strobe;
    #1 v = host_rdata;
    host_rd = 0;
  endtask

  task automatic store(input logic [4:0] a, input logic [7:0] d);
    setreg(8'h06, {3'd0, a[4]});
    setreg(8'h04, d[3:0]);
    setreg(8'h05, d[7:4]);
    setreg(8'h07, a[3:0]);
  endtask

  task automatic fetch_check(input string req, input logic [4:0] a);
    logic [7:0] v;
    setreg(8'h06, {3'd1, a[4]});
    setreg(8'h07, a[3:0]);
    wr(3'd5, 1, 8'h0C); rd(3'd5, 0, 1, v);
    check(req, v, exp_result(0, {3'd1, a[4]}, model[a]));
    wr(3'd5, 1, 8'h0D); rd(3'd5, 0, 1, v);
    check(req, v, exp_result(1, {3'd1, a[4]}, model[a]));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [3:0] lo, hi;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 bank", rom_bank, 8'h00);
    rd(3'd5, 0, 1, v); check("R1 even read idx0", v, 8'hF1);

    // R8, R11
    rd(3'd5, 1, 1, v); check("R8 odd read", v, 8'hFF);
    rd(3'd5, 0, 0, v); check("R11 no strobe", v, 8'hFF);
    rd(3'd3, 0, 1, v); check("R11 off window", v, 8'hFF);

    // R9 ready index and other indices
    wr(3'd5, 1, 8'h0A); rd(3'd5, 0, 1, v); check("R9 idx 0A", v, 8'hF1);
    wr(3'd5, 1, 8'h33); rd(3'd5, 0, 1, v); check("R3 R9 idx 33", v, 8'hF1);

    // R5 bank sweep over all 5-bit values
    for (int b = 0; b < 32; b++) begin
      setreg(8'h00, 4'(b));
      setreg(8'h01, 4'(b >> 4));
      check("R5 bank sweep", rom_bank, exp_bank(4'(b >> 4), 4'(b)));
    end
    lo = 4'h9; hi = 4'hC;
    for (int k = 0; k < 6; k++) begin
      lo = 4'($urandom); hi = 4'($urandom);
      setreg(8'h01, hi); setreg(8'h00, lo);
      check("R5 random bank", rom_bank, exp_bank(hi, lo));
    end

    // R2 writes off the window
    wr(3'd4, 1, 8'h00); wr(3'd4, 0, 8'h03);
    wr(3'd7, 0, 8'h05);
    check("R2 off-window bank", rom_bank, exp_bank(hi, lo));

    // R4 indices 8 and 0x10 store nothing
    wr(3'd5, 1, 8'h10); wr(3'd5, 0, {4'h0, ~lo});
    check("R4 idx 10 ignored", rom_bank, exp_bank(hi, lo));
    wr(3'd5, 1, 8'h08); wr(3'd5, 0, {4'h0, ~lo});
    check("R4 idx 08 ignored", rom_bank, exp_bank(hi, lo));

    // R6 store every location, R10 read both nibbles back
    for (int a = 0; a < 32; a++) begin
      model[a] = 8'($urandom);
      if (a == 5)  model[a] = 8'hA5;
      if (a == 21) model[a] = 8'h5A;
      store(5'(a), model[a]);
    end
    for (int a = 0; a < 32; a++) fetch_check("R6 R10 readback", 5'(a));

    // R10 result read without fetch command returns F0
    setreg(8'h06, 4'h4); setreg(8'h07, 4'h5);
    wr(3'd5, 1, 8'h0C); rd(3'd5, 0, 1, v); check("R10 no fetch lo", v, 8'hF0);
    wr(3'd5, 1, 8'h0D); rd(3'd5, 0, 1, v); check("R10 no fetch hi", v, 8'hF0);

    // R7 non-store commands leave RAM alone
    setreg(8'h04, ~model[5][3:0]); setreg(8'h05, ~model[5][7:4]);
    setreg(8'h06, 4'h4); setreg(8'h07, 4'h5);
    setreg(8'h06, 4'h3); setreg(8'h07, 4'h5);
    fetch_check("R7 ignored command", 5'd21);
    fetch_check("R7 ignored command", 5'd5);

    // R4 index 0x16 (low bits = control) must not change control
    setreg(8'h06, 4'h2); setreg(8'h07, 4'h5);
    wr(3'd5, 1, 8'h16); wr(3'd5, 0, 8'h00);
    wr(3'd5, 1, 8'h0C); rd(3'd5, 0, 1, v);
    check("R4 idx 16 ignored", v, exp_result(0, 4'h2, model[5]));

    finish_run();
  end
endmodule